// File: doc/BRIEF.md
# Bouncing Box Animation Controller

This block animates a 4x4 filled box on a 160x120 pixel screen. The box moves one pixel diagonally at a time and bounces off the four screen edges. The block writes pixels through a simple interface made of an X coordinate, a Y coordinate, a 3-bit RGB colour and a plot strobe. The frame buffer that takes these writes, and the display timing that scans it out, are outside the block.

The motion is paced by two counters. One counts clock cycles up to one frame period, which is 1/60 s at the default 50 MHz clock. The other counts elapsed frames. The box first appears at the upper-right corner and heads down-left. In a loop, the block draws the box in the colour present on its colour input, then idles for 15 frames. It then erases the box by plotting the same footprint in black through the same sweep, and finally steps the position. At 60 frames per second the box therefore moves 4 pixels per second.

The frame period is a parameter, so that a simulation can run with a period of a few cycles.

Top module: `box_bounce_anim`

## Requirements
- R1: While reset is held, `plot_o` is 0. After reset the first box is drawn with its upper-left corner at X=156, Y=0.
- R2: A draw holds `plot_o` high for exactly 16 consecutive cycles. It visits the pixels (X+c, Y+r) with the column c varying fastest, c and r each running 0..3, and drives `px_colour_o` equal to `colour_i`, where bit 2 is red, bit 1 is green and bit 0 is blue.
- R3: Between the last pixel of a draw and the first pixel of the following erase, `plot_o` stays low for exactly 15 x FRAME_CYCLES cycles.
- R4: An erase holds `plot_o` high for 16 consecutive cycles over the same footprint and in the same order as the draw before it. `px_colour_o` is 000 during the erase, whatever `colour_i` is.
- R5: After an erase, `plot_o` is low for exactly one cycle. The next draw then starts at a position that has moved by exactly one pixel on each axis.
- R6: The starting direction is down-left: X decreases and Y increases.
- R7: A step that would place the box's upper-left corner beyond X range 0..156 or Y range 0..116 instead reverses that axis' direction. The box then moves one pixel the other way in the same step.
- R8: Every plotted pixel lies inside the screen (X < 160, Y < 120). The box position always stays within its legal range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| colour_i | input | 3 | Colour of the box when it is drawn (R,G,B) |
| px_x_o | output | 8 | X coordinate of the pixel being written |
| px_y_o | output | 7 | Y coordinate of the pixel being written |
| px_colour_o | output | 3 | Colour of the pixel being written |
| plot_o | output | 1 | Pixel write strobe, one pixel per cycle |

## Verification
The hardest behaviour to reach from the ports is a bounce. The box must travel 116 steps before it reaches the bottom edge, 156 steps before it reaches the left edge, and 232 steps before it returns to the top. For this reason the bench shortens the frame period to 4 cycles and lets the box run 240 steps, which passes through the bottom, left and top reversals. The bench also changes the colour input during every erase, so it can show that the erase ignores the input while the next draw follows it.

// File: rtl/box_anim_pkg.sv
package box_anim_pkg;
  typedef enum logic [1:0] {
    ST_DRAW  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ERASE = 2'd2,
    ST_MOVE  = 2'd3
  } anim_st_t;
endpackage

// File: rtl/box_pacer.sv
// Frame-period delay counter plus frame counter; done when the last cycle of
// the last frame of the wait is reached. Both counters clear whenever idle.
module box_pacer #(
  parameter int FRAME_CYC = 833333,
  parameter int FRAMES    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int DW = $clog2(FRAME_CYC + 1);
  localparam int FW = $clog2(FRAMES + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(FRAME_CYC - 1);
  localparam logic [FW-1:0] FRM_LAST = FW'(FRAMES - 1);

  logic [DW-1:0] dly_q, dly_d;
  logic [FW-1:0] frm_q, frm_d;
  logic          frame_end;

  assign frame_end = (dly_q == DLY_LAST);
  assign done_o    = run_i && frame_end && (frm_q == FRM_LAST);

  always_comb begin
    dly_d = dly_q;
    frm_d = frm_q;
    if (!run_i) begin
      dly_d = '0;
      frm_d = '0;
    end else if (frame_end) begin
      dly_d = '0;
      frm_d = frm_q + FW'(1);
    end else begin
      dly_d = dly_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      frm_q <= '0;
    end else begin
      dly_q <= dly_d;
      frm_q <= frm_d;
    end
  end
endmodule

// File: rtl/box_painter.sv
// Sweeps the BOX x BOX footprint, column fastest, one pixel per enabled cycle.
module box_painter #(
  parameter int BOX = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  output logic [$clog2(BOX)-1:0] col_o,
  output logic [$clog2(BOX)-1:0] row_o,
  output logic                   last_o
);
  localparam int CW = $clog2(BOX);
  localparam int NW = 2 * CW;

  logic [NW-1:0] cnt_q, cnt_d;

  assign col_o  = cnt_q[CW-1:0];
  assign row_o  = cnt_q[NW-1:CW];
  assign last_o = en_i && (cnt_q == {NW{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || last_o) cnt_d = '0;
    else                 cnt_d = cnt_q + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/box_axis.sv
// One up/down position counter with its direction bit (1 = increasing).
// At a limit the direction reverses and the step goes the new way at once.
module box_axis #(
  parameter int W        = 8,
  parameter int MAX_POS  = 156,
  parameter int INIT_POS = 156,
  parameter bit INIT_DIR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] pos_o
);
  localparam logic [W-1:0] LIM = W'(MAX_POS);

  logic [W-1:0] pos_q, pos_d;
  logic         dir_q, dir_d;

  assign pos_o = pos_q;

  always_comb begin
    pos_d = pos_q;
    dir_d = dir_q;
    if (step_i) begin
      if (dir_q && pos_q == LIM) begin
        dir_d = 1'b0;
        pos_d = pos_q - W'(1);
      end else if (!dir_q && pos_q == '0) begin
        dir_d = 1'b1;
        pos_d = pos_q + W'(1);
      end else if (dir_q) begin
        pos_d = pos_q + W'(1);
      end else begin
        pos_d = pos_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= W'(INIT_POS);
      dir_q <= INIT_DIR;
    end else begin
      pos_q <= pos_d;
      dir_q <= dir_d;
    end
  end
endmodule

// File: rtl/box_bounce_anim.sv
module box_bounce_anim #(
  parameter int SCR_W     = 160,
  parameter int SCR_H     = 120,
  parameter int BOX       = 4,
  parameter int FRAME_CYC = 833333,
  parameter int FRAMES    = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] colour_i,
  output logic [7:0] px_x_o,
  output logic [6:0] px_y_o,
  output logic [2:0] px_colour_o,
  output logic       plot_o
);
  import box_anim_pkg::*;

  localparam int XW   = 8;
  localparam int YW   = 7;
  localparam int CW   = $clog2(BOX);
  localparam int XMAX = SCR_W - BOX;
  localparam int YMAX = SCR_H - BOX;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  anim_st_t st_q, st_d;
  logic     painting, paint_last, wait_done, step_en;
  logic [CW-1:0] col, row;
  logic [XW-1:0] pos_x;
  logic [YW-1:0] pos_y;

  assign painting = (st_q == ST_DRAW) || (st_q == ST_ERASE);
  assign step_en  = (st_q == ST_MOVE);

  box_painter #(.BOX(BOX)) u_painter (
    .clk(clk), .rst_n(rst_s_n), .en_i(painting),
    .col_o(col), .row_o(row), .last_o(paint_last)
  );

  box_pacer #(.FRAME_CYC(FRAME_CYC), .FRAMES(FRAMES)) u_pacer (
    .clk(clk), .rst_n(rst_s_n), .run_i(st_q == ST_WAIT), .done_o(wait_done)
  );

  box_axis #(.W(XW), .MAX_POS(XMAX), .INIT_POS(XMAX), .INIT_DIR(1'b0)) u_axis_x (
    .clk(clk), .rst_n(rst_s_n), .step_i(step_en), .pos_o(pos_x)
  );

  box_axis #(.W(YW), .MAX_POS(YMAX), .INIT_POS(0), .INIT_DIR(1'b1)) u_axis_y (
    .clk(clk), .rst_n(rst_s_n), .step_i(step_en), .pos_o(pos_y)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DRAW:  if (paint_last) st_d = ST_WAIT;
      ST_WAIT:  if (wait_done)  st_d = ST_ERASE;
      ST_ERASE: if (paint_last) st_d = ST_MOVE;
      ST_MOVE:                  st_d = ST_DRAW;
      default:                  st_d = ST_DRAW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= ST_DRAW;
    else          st_q <= st_d;
  end

  assign plot_o      = painting && rst_s_n;
  assign px_x_o      = pos_x + XW'(col);
  assign px_y_o      = pos_y + YW'(row);
  assign px_colour_o = (st_q == ST_DRAW) ? colour_i : 3'b000;
endmodule

// File: rtl/box_bounce_anim_chk.sv
module box_bounce_anim_chk #(
  parameter int SCR_W = 160,
  parameter int SCR_H = 120,
  parameter int BOX   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       plot,
  input logic [7:0] px_x,
  input logic [6:0] px_y,
  input logic [2:0] px_colour,
  input logic [1:0] st,
  input logic [7:0] pos_x,
  input logic [6:0] pos_y
);
  localparam int RUN = BOX * BOX;

  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (plot) run_q <= run_q + 8'd1;
    else           run_q <= '0;
  end

  a_r8_on_screen: assert property (@(posedge clk) disable iff (!rst_n)
    plot |-> (int'(px_x) < SCR_W) && (int'(px_y) < SCR_H));

  a_r8_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos_x) <= SCR_W - BOX) && (int'(pos_y) <= SCR_H - BOX));

  a_r4_erase_black: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> (px_colour == 3'b000));

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!plot && run_q != 8'd0) |-> (int'(run_q) == RUN));

  a_r2_run_max: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= RUN);

  a_r5_still_while_plot: assert property (@(posedge clk) disable iff (!rst_n)
    (plot && $past(plot)) |-> ($stable(pos_x) && $stable(pos_y)));

  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_x != $past(pos_x)) |->
      ((pos_x == $past(pos_x) + 8'd1) || (pos_x == $past(pos_x) - 8'd1)));
endmodule

bind box_bounce_anim box_bounce_anim_chk #(.SCR_W(SCR_W), .SCR_H(SCR_H), .BOX(BOX)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .plot(plot_o), .px_x(px_x_o), .px_y(px_y_o),
  .px_colour(px_colour_o), .st(st_q), .pos_x(pos_x), .pos_y(pos_y)
);

// File: tb/box_bounce_anim_tb.sv
`timescale 1ns/1ps
module box_bounce_anim_tb;
  localparam int FC     = 4;
  localparam int NMOVES = 240;

  typedef struct {
    int    x;
    int    y;
    int    c;
    int    gap;
    string tag;
    string gtag;
  } pix_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] colour_i;
  logic [7:0] px_x_o;
  logic [6:0] px_y_o;
  logic [2:0] px_colour_o;
  logic       plot_o;

  int   checks = 0;
  int   errors = 0;
  int   popped = 0;
  int   gap    = 0;
  bit   done   = 1'b0;
  pix_t q[$];

  always #10 clk = ~clk;

  box_bounce_anim #(.FRAME_CYC(FC)) u_dut (
    .clk(clk), .rst_n(rst_n), .colour_i(colour_i), .px_x_o(px_x_o),
    .px_y_o(px_y_o), .px_colour_o(px_colour_o), .plot_o(plot_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_box(input int x, input int y, input int c, input int g,
                          input string tag, input string gtag);
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) begin
        pix_t p;
        p.x = x + k; p.y = y + r; p.c = c;
        p.gap  = (r == 0 && k == 0) ? g : -1;
        p.tag  = tag; p.gtag = gtag;
        q.push_back(p);
      end
  endtask

  // monitor: pops expected pixels as the design plots them
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (plot_o) begin
        chk(px_x_o < 8'd160 && px_y_o < 7'd120, "R8", "pixel on screen",
            int'(px_x_o), int'(px_y_o));
        if (q.size() == 0) begin
          chk(1'b0, "R2", "unexpected plot", 1, 0);
        end else begin
          pix_t p;
          p = q.pop_front();
          if (p.gap >= 0) chk(gap == p.gap, p.gtag, "idle gap", gap, p.gap);
          chk(int'(px_x_o) == p.x, p.tag, "x", int'(px_x_o), p.x);
          chk(int'(px_y_o) == p.y, p.tag, "y", int'(px_y_o), p.y);
          chk(int'(px_colour_o) == p.c, p.tag, "colour", int'(px_colour_o), p.c);
        end
        popped++;
        gap = 0;
      end else begin
        gap++;
      end
    end
  end

  // driver: model of position, direction and colour
  initial begin
    int    mx, my, col;
    bit    hd, vd, bounced;
    string dtag;
    rst_n = 1'b0; colour_i = 3'd1;
    mx = 156; my = 0; hd = 1'b0; vd = 1'b1; col = 1; bounced = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(plot_o == 1'b0, "R1", "plot during reset", int'(plot_o), 0);
    end
    push_box(mx, my, col, -1, "R1", "R1");
    push_box(mx, my, 0, 15 * FC, "R4", "R3");
    rst_n = 1'b1;
    for (int k = 0; k < NMOVES; k++) begin
      wait (popped >= 32 * k + 17);
      @(negedge clk);
      col = (k % 7) + 1;
      if (k == 6) col = 0;
      colour_i = 3'(col + 1 > 7 ? 3 : col + 1);
      col = int'(colour_i);
      bounced = 1'b0;
      if (hd && mx == 156) begin hd = 1'b0; mx--; bounced = 1'b1; end
      else if (!hd && mx == 0) begin hd = 1'b1; mx++; bounced = 1'b1; end
      else if (hd) mx++; else mx--;
      if (vd && my == 116) begin vd = 1'b0; my--; bounced = 1'b1; end
      else if (!vd && my == 0) begin vd = 1'b1; my++; bounced = 1'b1; end
      else if (vd) my++; else my--;
      dtag = bounced ? "R7" : (k == 0 ? "R6" : "R2");
      push_box(mx, my, col, 1, dtag, "R5");
      push_box(mx, my, 0, 15 * FC, "R4", "R3");
    end
    wait (popped >= 32 * NMOVES + 16);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule